// File: doc/BRIEF.md
# Burst-Capable Auto-Refresh Scheduler

This block decides when an SDRAM controller owes the memory an auto-refresh. It counts controller clocks against a programmed interval and keeps a ledger of refreshes that are due but not yet carried out. While the ledger is non-zero it raises a request toward the command arbiter. Each grant pulse from the arbiter settles one owed refresh. Issuing the refresh command itself and closing open banks belong to the controller, not to this block.

Two modes can be chosen at run time. In single mode one refresh becomes due each time the base interval runs out. In burst mode the block waits eight times as long and then owes eight refreshes at once. The arbiter can then group them back to back. A package function turns a clock frequency in MHz into the base interval: 8192 refreshes per 64 ms gives floor(64000 × MHz / 8192) clocks, which is 3125 at 400 MHz.

Top module: `refresh_scheduler`

## Requirements
- R1: While `rst_n` is low at a clock edge, the ledger is cleared. After that edge `owed_count` is 0 and `refresh_req` is 0, whatever the other inputs are.
- R2: A clock edge with `refresh_en` low clears both the interval counter and the ledger. After re-enabling, the first refresh is owed only once a full period of enabled edges has passed. While the block is disabled nothing is ever owed.
- R3: With `burst_en` = 0 (single mode) the period P equals `interval`. The ledger gains 1 on every P-th consecutive enabled clock edge, so after k enabled edges with no grants `owed_count` = min(16, floor(k/P)).
- R4: With `burst_en` = 1 (burst mode) the period P equals 8 × `interval`. The ledger gains 8 on every P-th enabled edge, so after k enabled edges with no grants `owed_count` = min(16, 8 × floor(k/P)).
- R5: `refresh_req` is 1 exactly when `owed_count` is non-zero.
- R6: A `refresh_grant` high at an edge lowers the ledger by one when it is non-zero. A grant while the ledger is zero has no effect, and `owed_count` stays 0.
- R7: The ledger saturates at 16. Credits that would push it above 16 are dropped.
- R8: When a period runs out at the same edge as a valid grant, the ledger changes by the credit minus one, then is capped at 16.
- R9: A period of 0 behaves like a period of 1: a credit on every enabled edge, in either mode.
- R10: The helper function `refsched_base_interval(mhz)` returns floor(64000 × mhz / 8192), for example 3125 for 400, 1562 for 200 and 781 for 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_en | input | 1 | Refresh generation enable; low clears counter and ledger |
| burst_en | input | 1 | 1 selects burst mode (8× period, 8 credits), 0 selects single mode |
| interval | input | IVL_W (16) | Base interval in clocks |
| refresh_grant | input | 1 | One-cycle pulse from the arbiter, one per refresh carried out |
| refresh_req | output | 1 | A refresh is owed |
| owed_count | output | $clog2(OWED_MAX+1) (5) | Number of refreshes currently owed |

## Verification
The embedded properties assume that `refresh_grant` is a pulse meant for one refresh, and they count a grant seen at an edge as exactly one. They also assume that the burst factor fits below the saturation limit, so an eightfold credit is visible in full when the ledger is low. The stimulus changes mode and interval only while the block is disabled, or just after an expiry. This keeps every expected count a plain function of enabled edges, period and grants. The sweeps go over small intervals, including zero, so that periods, saturation and grant collisions all occur within a few dozen cycles.

// File: rtl/refsched_pkg.sv
// Package: shared helpers and types for the refresh scheduler.
// Assumes: callers pass the controller clock in whole MHz.
package refsched_pkg;

    // Refresh mode selected by the burst enable input.
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_BURST  = 1'b1
    } refsched_mode_e;

    // Base refresh interval in clocks: 8192 refreshes per 64 ms window.
    function automatic int unsigned refsched_base_interval(input int unsigned clk_mhz);
        return (64000 * clk_mhz) / 8192;
    endfunction

endpackage

// File: rtl/refsched_period.sv
// Module: refsched_period
// Turns the base interval and mode into an effective period and a
// per-expiry credit. Purely combinational.
// Assumes: BURST_FACTOR >= 1.
module refsched_period
    import refsched_pkg::*;
#(
    parameter int IVL_W        = 16,
    parameter int BURST_FACTOR = 8,
    parameter int PER_W        = IVL_W + $clog2(BURST_FACTOR),
    parameter int CRED_W       = $clog2(BURST_FACTOR + 1)
) (
    input  logic [IVL_W-1:0]  interval,
    input  refsched_mode_e    mode,
    output logic [PER_W-1:0]  period,
    output logic [CRED_W-1:0] credit
);

    localparam int SHIFT  = $clog2(BURST_FACTOR);
    localparam bit IS_POW = ((1 << SHIFT) == BURST_FACTOR);

    logic [PER_W-1:0] stretched;

    // Pick a shift when the burst factor is a power of two, else a multiply.
    generate
        if (IS_POW) begin : g_shift
            assign stretched = PER_W'(interval) << SHIFT;
        end else begin : g_mult
            assign stretched = PER_W'(interval) * PER_W'(BURST_FACTOR);
        end
    endgenerate

    // Select period and credit size from the mode.
    always_comb begin
        if (mode == MODE_BURST) begin
            period = stretched;
            credit = CRED_W'(BURST_FACTOR);
        end else begin
            period = PER_W'(interval);
            credit = CRED_W'(1);
        end
    end

endmodule

// File: rtl/refsched_timer.sv
// Module: refsched_timer
// Counts enabled clocks and pulses expire on the last cycle of each period.
// Assumes: a period of 0 is handled like 1; disable clears the count.
module refsched_timer #(
    parameter int PER_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PER_W-1:0] period,
    output logic             expire
);

    logic [PER_W-1:0] count;
    logic [PER_W:0]   count_inc;

    // Next count value, one bit wider so the compare cannot wrap.
    assign count_inc = {1'b0, count} + {{PER_W{1'b0}}, 1'b1};

    // Expiry when this enabled edge completes the period (or overshoots it).
    assign expire = enable && (count_inc >= {1'b0, period});

    // Interval counter: cleared by reset, disable or expiry, else advances.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            count <= '0;
        end else if (expire) begin
            count <= '0;
        end else begin
            count <= count_inc[PER_W-1:0];
        end
    end

    AST_TIMER_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0)); // R2

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == '0)); // R3

endmodule

// File: rtl/refsched_ledger.sv
// Module: refsched_ledger
// Saturating count of owed refreshes: adds credits, removes one per grant.
// Assumes: take is one refresh per asserted cycle; clear wins over all.
module refsched_ledger #(
    parameter int OWED_MAX = 16,
    parameter int CRED_W   = 4,
    parameter int OWED_W   = $clog2(OWED_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [CRED_W-1:0] add,
    input  logic              take,
    output logic [OWED_W-1:0] owed,
    output logic              pending
);

    localparam int SUM_W = $clog2(OWED_MAX + (1 << CRED_W) + 1);

    logic             dec;
    logic [SUM_W-1:0] sum;
    logic [OWED_W-1:0] owed_nxt;

    // A grant counts only against a non-empty ledger.
    assign dec = take && (owed != '0);

    // Credit in, grant out, then cap at the limit.
    always_comb begin
        sum = SUM_W'(owed) + SUM_W'(add) - SUM_W'(dec);
        if (sum > SUM_W'(OWED_MAX)) begin
            owed_nxt = OWED_W'(OWED_MAX);
        end else begin
            owed_nxt = sum[OWED_W-1:0];
        end
    end

    // Ledger register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed <= '0;
        end else begin
            owed <= owed_nxt;
        end
    end

    // Request flag follows the ledger.
    assign pending = (owed != '0);

    AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OWED_W'(OWED_MAX)); // R7

    AST_TAKE_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && owed != '0 && add == '0 && !clear) |=> (owed == $past(owed) - 1'b1)); // R6

    AST_EMPTY_TAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && owed == '0 && add == '0 && !clear) |=> (owed == '0)); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (owed == '0)); // R2

endmodule

// File: rtl/refresh_scheduler.sv
// Module: refresh_scheduler (top)
// Raises refresh requests at a programmed interval in single or burst mode
// and tracks how many are owed until the arbiter grants them.
// Assumes: refresh_grant is one pulse per refresh actually issued.
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int IVL_W        = 16,
    parameter int BURST_FACTOR = 8,
    parameter int OWED_MAX     = 16,
    parameter int OWED_W       = $clog2(OWED_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_en,
    input  logic              burst_en,
    input  logic [IVL_W-1:0]  interval,
    input  logic              refresh_grant,
    output logic              refresh_req,
    output logic [OWED_W-1:0] owed_count
);

    localparam int PER_W  = IVL_W + $clog2(BURST_FACTOR);
    localparam int CRED_W = $clog2(BURST_FACTOR + 1);

    refsched_mode_e    mode;
    logic [PER_W-1:0]  period;
    logic [CRED_W-1:0] credit;
    logic [CRED_W-1:0] credit_now;
    logic              expire;

    // Mode decode from the burst enable pin.
    assign mode = burst_en ? MODE_BURST : MODE_SINGLE;

    // Credit is applied only on an expiry edge.
    assign credit_now = expire ? credit : '0;

    refsched_period #(
        .IVL_W        (IVL_W),
        .BURST_FACTOR (BURST_FACTOR),
        .PER_W        (PER_W),
        .CRED_W       (CRED_W)
    ) period_i (
        .interval (interval),
        .mode     (mode),
        .period   (period),
        .credit   (credit)
    );

    refsched_timer #(
        .PER_W (PER_W)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (refresh_en),
        .period (period),
        .expire (expire)
    );

    refsched_ledger #(
        .OWED_MAX (OWED_MAX),
        .CRED_W   (CRED_W),
        .OWED_W   (OWED_W)
    ) ledger_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!refresh_en),
        .add     (credit_now),
        .take    (refresh_grant),
        .owed    (owed_count),
        .pending (refresh_req)
    );

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_en |=> !refresh_req); // R2

    AST_REQ_TRACKS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req == (owed_count != '0)); // R5

    AST_BURST_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && burst_en && !refresh_grant && int'(owed_count) <= OWED_MAX - BURST_FACTOR)
        |=> (int'(owed_count) == int'($past(owed_count)) + BURST_FACTOR)); // R4

    AST_SINGLE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !burst_en && !refresh_grant && int'(owed_count) < OWED_MAX)
        |=> (int'(owed_count) == int'($past(owed_count)) + 1)); // R3

endmodule

// File: tb/refresh_scheduler_tb_top.sv
`timescale 1ns/1ps
module refresh_scheduler_tb_top;
    import refsched_pkg::*;

    localparam int IVL_W = 16;
    localparam int BF    = 8;
    localparam int OMAX  = 16;
    localparam int OW    = $clog2(OMAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             burst = 1'b0;
    logic             grant = 1'b0;
    logic [IVL_W-1:0] ivl = '0;
    logic             req;
    logic [OW-1:0]    owed;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    refresh_scheduler #(.IVL_W(IVL_W), .BURST_FACTOR(BF), .OWED_MAX(OMAX)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_en    (en),
        .burst_en      (burst),
        .interval      (ivl),
        .refresh_grant (grant),
        .refresh_req   (req),
        .owed_count    (owed)
    );

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int exp_owed(input bit b, input int iv, input int k);
        int p;
        int n;
        p = b ? iv * BF : iv;
        if (p < 1) p = 1;
        n = (k / p) * (b ? BF : 1);
        return (n > OMAX) ? OMAX : n;
    endfunction

    // One disabled edge to clear, then k enabled edges, then compare.
    task automatic sweep(input bit b, input int iv, input int k, input string r);
        int e;
        @(negedge clk); en = 1'b0; grant = 1'b0;
        @(negedge clk); burst = b; ivl = IVL_W'(iv); en = 1'b1;
        repeat (k) @(posedge clk);
        @(negedge clk);
        e = exp_owed(b, iv, k);
        chk(r, int'(owed), e);
        chk("R5", int'(req), int'(e != 0));
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the ledger empty even with a fast burst setup.
        en = 1'b1; burst = 1'b1; ivl = 1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(owed), 0);
        chk("R1", int'(req), 0);
        en = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        // R10: helper function values.
        chk("R10", int'(refsched_base_interval(400)), 3125);
        chk("R10", int'(refsched_base_interval(200)), 1562);
        chk("R10", int'(refsched_base_interval(100)), 781);

        // R3 and R9: single-mode sweep including period 0.
        for (int iv = 0; iv <= 6; iv++) begin
            for (int k = 1; k <= 2 * (iv < 1 ? 1 : iv) + 2; k++) begin
                sweep(1'b0, iv, k, (iv <= 1) ? "R9" : "R3");
            end
        end
        // R7: long single run saturates.
        sweep(1'b0, 1, 25, "R7");

        // R4 and R9: burst-mode sweep including period 0.
        for (int iv = 0; iv <= 2; iv++) begin
            for (int k = 1; k <= 2 * (iv < 1 ? 1 : iv * BF) + 2; k++) begin
                sweep(1'b1, iv, k, (iv == 0) ? "R9" : "R4");
            end
        end
        // R7: burst credits saturate.
        sweep(1'b1, 1, 40, "R7");

        // R2: disabling mid-count restarts the period.
        @(negedge clk); en = 1'b0;
        @(negedge clk); burst = 1'b0; ivl = 5; en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2", int'(owed), 0);
        @(posedge clk); @(negedge clk);
        chk("R2", int'(owed), 1);

        // R2: disable empties a full ledger and nothing accrues while off.
        @(negedge clk); en = 1'b0;
        @(negedge clk); burst = 1'b1; ivl = 1; en = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R4", int'(owed), 8);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R2", int'(owed), 0);
        chk("R2", int'(req), 0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R2", int'(owed), 0);

        // R6: grants drain the ledger one by one, then are ignored.
        burst = 1'b1; ivl = 1; en = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        ivl = 1000; burst = 1'b0;
        for (int g = 7; g >= 0; g--) begin
            grant = 1'b1;
            @(posedge clk); @(negedge clk);
            chk("R6", int'(owed), g);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6", int'(owed), 0);
        chk("R6", int'(req), 0);
        grant = 1'b0;

        // R8: expiry and grant on the same edge.
        @(negedge clk); en = 1'b0;
        @(negedge clk); burst = 1'b0; ivl = 2; en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R3", int'(owed), 2);
        grant = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R6", int'(owed), 1);
        @(posedge clk); @(negedge clk);
        chk("R8", int'(owed), 1);
        grant = 1'b0;

        // R8 with R7: full ledger, burst expiry plus grant stays capped.
        @(negedge clk); en = 1'b0;
        @(negedge clk); burst = 1'b1; ivl = 1; en = 1'b1;
        repeat (16) @(posedge clk);
        @(negedge clk);
        chk("R7", int'(owed), 16);
        repeat (7) @(posedge clk);
        @(negedge clk); grant = 1'b1;
        @(posedge clk); @(negedge clk);
        grant = 1'b0;
        chk("R8", int'(owed), 16);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule